// File: doc/BRIEF.md
# Multi-Digit BCD Seven-Segment Decoder with Zero Suppression

This block turns a row of packed BCD digits into active-low seven-segment drives. It is meant for a numeric readout that has an integer part and a fractional part. Each digit position has a lamp-test control, a ripple-blank input and a ripple-blank output. The ripple-blank output and the per-digit blanking input would share one pin on a discrete part; here they are separate ports. The block is purely combinational.

Inside the block, digit decoders are chained. In the integer part a blanking request ripples from the most significant digit toward the decimal point. In the fraction it ripples from the least significant digit toward the decimal point. A zero is therefore dark only when every digit between it and the outer end of its part is also zero. Zeros that carry meaning stay lit. The two digits next to the decimal point never receive a ripple-blank request, so an all-zero value still reads "0.0". A lamp-test input lights every segment. A per-digit blanking input turns a digit dark no matter what the other inputs are.

Digit index 0 is the least significant fractional digit. Indices `FRAC_DIGITS` to `FRAC_DIGITS+INT_DIGITS-1` form the integer part, and the highest index is the most significant digit. Digit k occupies bits `[4k+3:4k]` of `digits_i` and bits `[7k+6:7k]` of `seg_n_o`.

Top module: `bcd_seg_chain`

## Requirements
- R1: Within a digit's 7-bit segment field, bit 0 drives segment a, bit 1 drives b, and so on up to bit 6, which drives g. A 0 lights a segment. With no blanking and lamp test off, codes 0 to 9 light these segment sets: 0:abcdef, 1:bc, 2:abdeg, 3:abcdg, 4:bcfg, 5:acdfg, 6:acdefg, 7:abc, 8:all, 9:abcdfg.
- R2: BCD codes 10 to 15 turn all seven segments of the digit off. A digit holding one of these codes never asserts its ripple-blank output.
- R3: When `lamp_test_n` is 0, every digit whose blanking input is inactive lights all seven segments, whatever its code and ripple state.
- R4: When a digit's `blank_n_i` bit is 0, all seven of its segments are off, whatever the lamp test, the code or the ripple state.
- R5: When a digit's ripple-blank input is active and its code is 0, the digit is dark. When the ripple-blank input is active and the code is nonzero, the digit shows its code normally.
- R6: A digit's `rbo_n_o` bit is 0 exactly when its code is 0 and its ripple-blank input is active. The lamp test and the blanking input do not affect it.
- R7: The most significant integer digit takes its ripple-blank input from `lead_rbi_n`. Every other integer digit takes it from the ripple-blank output of the next more significant digit.
- R8: The least significant fractional digit takes its ripple-blank input from `trail_rbi_n`. Every other fractional digit takes it from the ripple-blank output of the next less significant digit.
- R9: The least significant integer digit and the most significant fractional digit always see an inactive ripple-blank input, so a zero in either position is never blanked by rippling.
- R10: A zero stays lit when a nonzero digit stands on its more significant side in the integer part, or on its less significant side in the fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| digits_i | input | 4*(INT_DIGITS+FRAC_DIGITS) | Packed BCD digits; digit 0 is the least significant fraction digit |
| lamp_test_n | input | 1 | Active-low lamp test for all digits |
| blank_n_i | input | INT_DIGITS+FRAC_DIGITS | Active-low blanking input, one bit per digit |
| lead_rbi_n | input | 1 | Active-low ripple-blank input at the most significant integer digit |
| trail_rbi_n | input | 1 | Active-low ripple-blank input at the least significant fraction digit |
| seg_n_o | output | 7*(INT_DIGITS+FRAC_DIGITS) | Active-low segment drives, 7 bits per digit, bit 0 = a |
| rbo_n_o | output | INT_DIGITS+FRAC_DIGITS | Active-low ripple-blank output, one bit per digit |

## Verification
The digit table is exercised by filling every position with the same code for each of the ten values, with the chains idle. This separates glyph errors from chain errors. Readouts such as all zeros, "0105.20", "0030.05" and "0000.50" are run with both chain heads active. They show whether blanking stops at the first nonzero digit and whether it stops at the decimal point, and they confirm that the lone zeros beside the point stay lit. Runs with the chain heads inactive, with invalid codes in the leading position, and with lamp test combined with per-digit blanking separate the ripple terms from the two overrides and show their priority.

// File: rtl/bcd_seg_chain.sv
module bcd_seg_chain #(
  parameter int INT_DIGITS  = 4,
  parameter int FRAC_DIGITS = 2,
  localparam int NUM = INT_DIGITS + FRAC_DIGITS
) (
  input  logic [NUM*4-1:0] digits_i,
  input  logic             lamp_test_n,
  input  logic [NUM-1:0]   blank_n_i,
  input  logic             lead_rbi_n,
  input  logic             trail_rbi_n,
  output logic [NUM*7-1:0] seg_n_o,
  output logic [NUM-1:0]   rbo_n_o
);

  function automatic logic [6:0] glyph(input logic [3:0] v);
    case (v)
      4'd0: glyph = 7'h3F;
      4'd1: glyph = 7'h06;
      4'd2: glyph = 7'h5B;
      4'd3: glyph = 7'h4F;
      4'd4: glyph = 7'h66;
      4'd5: glyph = 7'h6D;
      4'd6: glyph = 7'h7D;
      4'd7: glyph = 7'h07;
      4'd8: glyph = 7'h7F;
      4'd9: glyph = 7'h6F;
      default: glyph = 7'h00;
    endcase
  endfunction

  logic [NUM-1:0] rbi_act;
  logic [NUM-1:0] rbo_act;

  always_comb begin
    logic run;
    rbi_act = '0;
    rbo_act = '0;
    run = !lead_rbi_n;
    for (int i = NUM - 1; i >= FRAC_DIGITS; i--) begin
      rbi_act[i] = (i != FRAC_DIGITS) && run;
      rbo_act[i] = rbi_act[i] && (digits_i[i*4 +: 4] == 4'd0);
      run = rbo_act[i];
    end
    run = !trail_rbi_n;
    for (int i = 0; i < FRAC_DIGITS; i++) begin
      rbi_act[i] = (i != FRAC_DIGITS - 1) && run;
      rbo_act[i] = rbi_act[i] && (digits_i[i*4 +: 4] == 4'd0);
      run = rbo_act[i];
    end
  end

  for (genvar g = 0; g < NUM; g++) begin : gen_digit
    logic [3:0] code;
    logic [6:0] lit;
    assign code = digits_i[g*4 +: 4];
    assign lit  = !blank_n_i[g] ? 7'h00 :
                  !lamp_test_n  ? 7'h7F :
                  rbo_act[g]    ? 7'h00 : glyph(code);
    assign seg_n_o[g*7 +: 7] = ~lit;
    assign rbo_n_o[g]        = ~rbo_act[g];

    always_comb begin
      if (!blank_n_i[g]) begin
        AST_BLANK_DARK: assert (&seg_n_o[g*7 +: 7]); // R4
      end
      if (blank_n_i[g] && !lamp_test_n) begin
        AST_LAMP_ALL_LIT: assert (seg_n_o[g*7 +: 7] == 7'h00); // R3
      end
      if (!rbo_n_o[g]) begin
        AST_RBO_ZERO_ONLY: assert (digits_i[g*4 +: 4] == 4'd0); // R6
      end
      if (digits_i[g*4 +: 4] > 4'd9) begin
        AST_BAD_CODE_NO_RBO: assert (rbo_n_o[g]); // R2
      end
    end

    if (g == FRAC_DIGITS || g == FRAC_DIGITS - 1) begin : gen_point
      always_comb begin
        if (blank_n_i[g] && digits_i[g*4 +: 4] == 4'd0) begin
          AST_POINT_ZERO_SHOWN: assert (seg_n_o[g*7 +: 7] != 7'h7F); // R9
        end
      end
    end
    if (g > FRAC_DIGITS && g < NUM - 1) begin : gen_lead_chk
      always_comb begin
        if (!rbo_n_o[g]) begin
          AST_LEAD_CHAIN: assert (!rbo_n_o[g+1]); // R7
        end
      end
    end
    if (g > 0 && g < FRAC_DIGITS - 1) begin : gen_trail_chk
      always_comb begin
        if (!rbo_n_o[g]) begin
          AST_TRAIL_CHAIN: assert (!rbo_n_o[g-1]); // R8
        end
      end
    end
  end

endmodule

// File: tb/sim_bcd_seg_chain.sv
`timescale 1ns/1ps
module sim_bcd_seg_chain;
  localparam int NI = 4;
  localparam int NF = 2;
  localparam int N  = NI + NF;

  typedef struct {
    logic [N*7-1:0] seg;
    logic [N-1:0]   rbo;
    string          tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N*4-1:0] digits = '0;
  logic lt_n = 1'b1;
  logic [N-1:0] bl_n = '1;
  logic lead_n = 1'b1;
  logic trail_n = 1'b1;
  logic [N*7-1:0] seg_n;
  logic [N-1:0] rbo_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  bcd_seg_chain #(.INT_DIGITS(NI), .FRAC_DIGITS(NF)) u0 (
    .digits_i(digits), .lamp_test_n(lt_n), .blank_n_i(bl_n),
    .lead_rbi_n(lead_n), .trail_rbi_n(trail_n),
    .seg_n_o(seg_n), .rbo_n_o(rbo_n));

  function automatic logic [6:0] pat(input logic [3:0] v);
    logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                          7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    return (v > 9) ? 7'h00 : t[v];
  endfunction

  task automatic apply(input logic [N*4-1:0] d, input logic lt, input logic [N-1:0] bl,
                       input logic ld, input logic tr, input string tag);
    exp_t e;
    logic ra [N];
    logic ro [N];
    logic run;
    for (int i = 0; i < N; i++) begin ra[i] = 1'b0; ro[i] = 1'b0; end
    run = !ld;
    for (int i = N - 1; i >= NF; i--) begin
      ra[i] = (i == NF) ? 1'b0 : run;
      ro[i] = ra[i] && d[i*4 +: 4] == 4'd0;
      run = ro[i];
    end
    run = !tr;
    for (int i = 0; i < NF; i++) begin
      ra[i] = (i == NF - 1) ? 1'b0 : run;
      ro[i] = ra[i] && d[i*4 +: 4] == 4'd0;
      run = ro[i];
    end
    for (int i = 0; i < N; i++) begin
      logic [6:0] l;
      l = !bl[i] ? 7'h00 : !lt ? 7'h7F : ro[i] ? 7'h00 : pat(d[i*4 +: 4]);
      e.seg[i*7 +: 7] = ~l;
      e.rbo[i] = ~ro[i];
    end
    e.tag = tag;
    @(negedge clk);
    digits = d; lt_n = lt; bl_n = bl; lead_n = ld; trail_n = tr;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks += 2;
      if (seg_n !== e.seg) begin
        errors++;
        $display("FAIL %s seg: actual %h expected %h", e.tag, seg_n, e.seg);
      end
      if (rbo_n !== e.rbo) begin
        errors++;
        $display("FAIL %s rbo: actual %b expected %b", e.tag, rbo_n, e.rbo);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    apply(24'h000000, 1'b1, 6'h3F, 1'b1, 1'b1, "R1 idle after reset");
    for (int v = 0; v < 10; v++)
      apply({6{v[3:0]}}, 1'b1, 6'h3F, 1'b1, 1'b1, "R1 glyph sweep");
    for (int v = 10; v < 16; v++)
      apply({v[3:0], 20'h00000}, 1'b1, 6'h3F, 1'b0, 1'b1, "R2 invalid code lead");
    apply(24'h000000, 1'b1, 6'h3F, 1'b0, 1'b0, "R9 all zero reads 0.0");
    apply(24'h010520, 1'b1, 6'h3F, 1'b0, 1'b0, "R10 R7 R8 0105.20");
    apply(24'h003005, 1'b1, 6'h3F, 1'b0, 1'b0, "R10 R9 0030.05");
    apply(24'h000050, 1'b1, 6'h3F, 1'b0, 1'b0, "R8 fraction 0000.50");
    apply(24'h123456, 1'b1, 6'h3F, 1'b0, 1'b0, "R5 nonzero with rbi");
    apply(24'h000000, 1'b1, 6'h3F, 1'b1, 1'b0, "R7 lead inactive");
    apply(24'h000000, 1'b1, 6'h3F, 1'b0, 1'b1, "R8 trail inactive");
    apply(24'h00F000, 1'b1, 6'h3F, 1'b0, 1'b0, "R2 R5 invalid stops chain");
    apply(24'h000000, 1'b0, 6'h3F, 1'b0, 1'b0, "R3 R6 lamp test on zeros");
    apply(24'hAB1200, 1'b0, 6'h3F, 1'b1, 1'b1, "R3 lamp test invalid");
    apply(24'h000000, 1'b0, 6'h15, 1'b0, 1'b0, "R4 R6 blank over lamp");
    apply(24'h987654, 1'b1, 6'h2A, 1'b1, 1'b1, "R4 blank digits");
    apply(24'h000007, 1'b1, 6'h3E, 1'b0, 1'b0, "R6 blank keeps rbo");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule